// File: doc/BRIEF.md
# Folded Thermometer-to-Binary Encoder

This block turns the 31-line thermometer word produced by a flash converter's comparator bank into a 5-bit binary count. The comparator lines enter the block without any input register. Two purely combinational stages do the conversion. The first stage folds the 31 lines onto 8 intermediate lines using AND-with-complement terms. The second stage forms the binary bits from XOR pairs of those lines, and ORs the pairs together where a bit needs more than one.

Only the encoded result is registered, once per clock. This leaves the full clock period for the comparators to settle and for both stages to propagate. Because there are 31 lines, every count from 0 to 31 fits in five bits and no overflow flag is needed. A word that is not a clean thermometer code, for example one with bubbles, still yields a fixed value set by the same equations. There is no separate error path.

Top module: `tfe_flash_encoder`

## Requirements
- R1: The input `therm_i` has 31 bits. Bit i carries comparator line C[i+1], so bit 0 is the lowest threshold. The output `bin_o` has 5 bits, with bit 0 as the LSB.
- R2: For each n from 1 to 7, fold line F[n] = (C[n] AND NOT C[n+8]) OR (C[n+16] AND NOT C[n+24]).
- R3: Fold line F[8] = (C[8] AND NOT C[16]) OR C[24].
- R4: The binary bits are formed as follows:
  - bit 4 = C[16];
  - bit 3 = F[8];
  - bit 2 = F[4] XOR F[8];
  - bit 1 = (F[2] XOR F[4]) OR (F[6] XOR F[8]);
  - bit 0 = (F[1] XOR F[2]) OR (F[3] XOR F[4]) OR (F[5] XOR F[6]) OR (F[7] XOR F[8]).
- R5: For a valid thermometer code with C[1..k] = 1 and all other lines 0 (0 ≤ k ≤ 31), `bin_o` equals k one clock after the code is sampled. For example, k = 20 gives 10100 and k = 31 gives 11111.
- R6: For a word that is not a thermometer code, `bin_o` takes the value given by R2–R4 for that word, with no error signalling.
- R7: While `rst_n` is low at a rising clock edge, `bin_o` becomes 0, whatever the input is. Reset is synchronous and active low.
- R8: `bin_o` changes only at rising clock edges. When the input changes between two edges, the output keeps the encoding of the word sampled at the previous edge until the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the output register captures on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset of the output register |
| therm_i | input | 31 | Comparator lines, bit i = C[i+1], unregistered |
| bin_o | output | 5 | Registered binary count |

## Verification
The assertions check four behaviours on every cycle:
- any clean thermometer word is registered as its population count;
- bit 4 follows C[16] from the previous cycle;
- an all-ones word folds to F[8] alone;
- reset clears the output on the following edge.

The fold and XOR equations for bubbled words are checked only by the bench, which compares those scenarios against an arithmetic model of R2–R4. The bench also covers the mid-cycle input change that shows the output is held between edges.

// File: rtl/tfe_pkg.sv
// Package: shared sizes of the folded thermometer encoder.
// Assumes the classic 2^OUT_W - 1 comparator-line configuration.
package tfe_pkg;
    localparam int OUT_W   = 5;
    localparam int IN_W    = (1 << OUT_W) - 1;    // 31 comparator lines
    localparam int MID_W   = 1 << (OUT_W - 2);    // 8 fold lines
    localparam int XOR_LVL = OUT_W - 2;           // bits formed by XOR pairs
endpackage

// File: rtl/tfe_fold_stage.sv
// Module: first stage. Folds the 31 thermometer lines onto 8 lines.
// Line n (index n-1) is high where the code edge falls in the n-th slot
// of the first or third group of eight. The last line also takes the
// upper half directly.
// Assumes IN_W = 4*MID_W - 1. Purely combinational.
module tfe_fold_stage #(
    parameter int IN_W  = tfe_pkg::IN_W,
    parameter int MID_W = tfe_pkg::MID_W
) (
    input  logic [IN_W-1:0]  therm,
    output logic [MID_W-1:0] fold
);
    localparam int Q1 = MID_W;
    localparam int Q2 = 2 * MID_W;
    localparam int Q3 = 3 * MID_W;

    // AND-with-complement pairs for the first seven lines
    for (genvar j = 0; j < MID_W - 1; j++) begin : g_fold
        assign fold[j] = (therm[j] & ~therm[j+Q1]) | (therm[j+Q2] & ~therm[j+Q3]);
    end

    // The top fold line takes the third-quarter line directly
    assign fold[MID_W-1] = (therm[MID_W-1] & ~therm[Q2-1]) | therm[Q3-1];
endmodule

// File: rtl/tfe_xor_stage.sv
// Module: second stage. Forms the binary bits from the fold lines.
// Bit L (L < XOR_LVL) ORs together XOR pairs taken at stride 2^L.
// The next bit is the top fold line, and the MSB is the mid comparator line.
// Purely combinational.
module tfe_xor_stage #(
    parameter int MID_W   = tfe_pkg::MID_W,
    parameter int OUT_W   = tfe_pkg::OUT_W,
    parameter int XOR_LVL = tfe_pkg::XOR_LVL
) (
    input  logic [MID_W-1:0] fold,
    input  logic             mid_line,
    output logic [OUT_W-1:0] bin
);
    for (genvar l = 0; l < XOR_LVL; l++) begin : g_lvl
        localparam int STEP = 1 << l;
        localparam int NPR  = MID_W >> (l + 1);
        logic [NPR-1:0] pair_x;
        // XOR of the lines at the two ends of each stride-2^l pair
        for (genvar m = 0; m < NPR; m++) begin : g_pair
            assign pair_x[m] = fold[m*2*STEP + STEP - 1] ^ fold[m*2*STEP + 2*STEP - 1];
        end
        assign bin[l] = |pair_x;
    end

    assign bin[OUT_W-2] = fold[MID_W-1];
    assign bin[OUT_W-1] = mid_line;
endmodule

// File: rtl/tfe_out_reg.sv
// Module: output register of the encoder, with synchronous active-low clear.
// Assumes the data input has settled within one clock period.
module tfe_out_reg #(
    parameter int W = tfe_pkg::OUT_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    // Capture the encoded value each edge; reset wins
    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end
endmodule

// File: rtl/tfe_flash_encoder.sv
// Module: top of the folded thermometer-to-binary encoder.
// Comparator lines go unregistered through fold and XOR stages into a
// single output register.
// Assumes therm_i meets setup to clk through both stages.
module tfe_flash_encoder #(
    parameter int OUT_W = tfe_pkg::OUT_W,
    parameter int IN_W  = tfe_pkg::IN_W,
    parameter int MID_W = tfe_pkg::MID_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IN_W-1:0]  therm_i,
    output logic [OUT_W-1:0] bin_o
);
    localparam int MID_IDX = (IN_W - 1) / 2;   // C[16]

    logic [MID_W-1:0] fold_w;
    logic [OUT_W-1:0] bin_w;

    tfe_fold_stage #(.IN_W(IN_W), .MID_W(MID_W)) u_fold (
        .therm (therm_i),
        .fold  (fold_w)
    );

    tfe_xor_stage #(.MID_W(MID_W), .OUT_W(OUT_W), .XOR_LVL(OUT_W - 2)) u_xor (
        .fold     (fold_w),
        .mid_line (therm_i[MID_IDX]),
        .bin      (bin_w)
    );

    tfe_out_reg #(.W(OUT_W)) u_reg (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (bin_w),
        .q     (bin_o)
    );

    // A clean thermometer word is registered as its count of ones
    assert_valid_count_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((therm_i & (therm_i + IN_W'(1))) == '0) |=> (bin_o == OUT_W'($countones($past(therm_i)))));

    // MSB follows the mid comparator line of the previous cycle
    assert_msb_direct_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (bin_o[OUT_W-1] == $past(therm_i[MID_IDX])));

    // All lines high folds onto the top fold line alone
    assert_full_fold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (&therm_i) |-> (fold_w == (MID_W'(1) << (MID_W - 1))));

    // Reset clears the register on the following edge
    assert_reset_clear_R7: assert property (@(posedge clk)
        !rst_n |=> (bin_o == '0));
endmodule

// File: tb/tfe_flash_encoder_test.sv
// Bench: sweeps every clean thermometer code, then bubbled words from an
// LFSR, checking against an arithmetic model of the fold/XOR equations.
module tfe_flash_encoder_test;
    localparam int CLK_PERIOD = 10;
    localparam int IN_W = 31;
    localparam int OUT_W = 5;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [IN_W-1:0] therm_i = '1;
    logic [OUT_W-1:0] bin_o;
    int total = 0;
    int bad = 0;
    logic [31:0] lfsr = 32'h1ACE_B00C;

    tfe_flash_encoder uut (.clk(clk), .rst_n(rst_n), .therm_i(therm_i), .bin_o(bin_o));

    always #(CLK_PERIOD/2) clk = ~clk;

    // Model of R2-R4; C[n] is bit n-1
    function automatic logic [4:0] model(input logic [30:0] w);
        logic [8:1] f;
        logic [4:0] r;
        for (int n = 1; n <= 7; n++)
            f[n] = (w[n-1] & ~w[n+7]) | (w[n+15] & ~w[n+23]);
        f[8] = (w[7] & ~w[15]) | w[23];
        r[0] = (f[1] ^ f[2]) | (f[3] ^ f[4]) | (f[5] ^ f[6]) | (f[7] ^ f[8]);
        r[1] = (f[2] ^ f[4]) | (f[6] ^ f[8]);
        r[2] = f[4] ^ f[8];
        r[3] = f[8];
        r[4] = w[15];
        return r;
    endfunction

    task automatic check(input string req, input logic [4:0] exp);
        total++;
        if (bin_o !== exp) begin
            bad++;
            $display("FAIL %s: in=%h got=%0d expected=%0d", req, therm_i, bin_o, exp);
        end
    endtask

    // Drive at negedge, let one posedge capture, sample at next negedge
    task automatic apply(input logic [30:0] w);
        therm_i = w;
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: run hung, got=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : stim
        logic [30:0] w;
        // R7: reset state with all lines high
        repeat (2) @(posedge clk);
        @(negedge clk);
        check("R7 reset state", 5'd0);
        rst_n = 1'b1;

        // R5, R1: every clean thermometer code, k ones
        for (int k = 0; k <= 31; k++) begin
            apply(31'((64'd1 << k) - 1));
            check("R5 valid code", 5'(k));
        end

        // R2, R3, R4: single-line and hand-picked bubbled words
        for (int i = 0; i < IN_W; i++) begin
            w = 31'(1) << i;
            apply(w);
            check("R2 R3 R4 single line", model(w));
        end
        apply(31'h00F0_0FFF);
        check("R6 bubble", model(31'h00F0_0FFF));
        apply(31'h7FFF_7FFF);
        check("R6 hole at C16", model(31'h7FFF_7FFF));

        // R6: pseudo-random non-thermometer words
        for (int i = 0; i < 400; i++) begin
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            apply(lfsr[30:0]);
            check("R6 random", model(lfsr[30:0]));
        end

        // R8: mid-cycle input change does not reach the output
        apply(31'h0000_FFFF);
        therm_i = 31'h0000_007F;
        #1;
        check("R8 hold between edges", 5'd16);
        @(posedge clk);
        @(negedge clk);
        check("R8 update at edge", 5'd7);

        // R7: reset takes priority over a full input
        therm_i = '1;
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check("R7 reset priority", 5'd0);
        rst_n = 1'b1;
        apply('1);
        check("R5 after reset", 5'd31);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule